// File: doc/BRIEF.md
# Packed Double-to-Single Converter

This block narrows two IEEE-754 binary64 numbers, carried side by side in a 128-bit input word, into two binary32 numbers. The two results sit in the low 64 bits of a 128-bit output word, and the upper 64 bits are driven to zero. A 2-bit rounding-mode input chooses how inexact results are rounded. Each transfer also carries a 5-bit exception vector. That vector is the bitwise OR of the conditions found in both lanes.

Operands enter on a valid/ready handshake. Both lanes are converted combinationally in the same cycle. The results are captured in a one-deep output register, which drives a second valid/ready handshake. When a special value occurs, the block returns the default IEEE result for it. Masking and trapping policy is left to the surrounding logic.

Top module: `dp2sp_pair`

## Requirements
- R1: Output bits [31:0] carry the narrowed value of input bits [63:0]. Output bits [63:32] carry the narrowed value of input bits [127:64].
- R2: Output bits [127:64] are zero on every transfer.
- R3: The rounding-mode encoding is 0 = nearest-even, 1 = toward minus infinity, 2 = toward plus infinity, 3 = toward zero. Every finite result is rounded in the selected mode. Flag bit 4 (precision) is set when the result is inexact.
- R4: When the rounded magnitude exceeds the binary32 range, flag bit 2 (overflow) and flag bit 4 are both set. The result is infinity in two cases: nearest-even, and rounding away from zero in the direction of the sign. In every other case the result is the largest finite value with the input sign.
- R5: An infinity or a zero converts exactly, keeps its sign and sets no flag. A NaN becomes a quiet NaN (exponent all ones, mantissa bit 22 set) that keeps the sign and the top 22 payload bits. A signalling NaN (fraction bit 51 clear) also sets flag bit 0 (invalid).
- R6: A subnormal binary64 input sets flag bit 1 (denormal), bit 3 and bit 4. Its result is zero, or the smallest subnormal when rounding is away from zero in the direction of the sign.
- R7: Results below 2^-126 before rounding are returned as correctly rounded binary32 subnormals. Such a result may round up to 2^-126. When it is both tiny and inexact, flag bit 3 (underflow) is set. A tiny result that is exact sets no flag.
- R8: The flags delivered with a transfer are the OR of both lanes' flags.
- R9: After reset, out_valid is low and in_ready is high.
- R10: A word moves in when in_valid and in_ready are both high. While out_valid is high and out_ready is low, out_data and out_flags hold steady and in_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 128 | Two binary64 operands, lane 0 in the low half |
| in_rmode | input | 2 | Rounding mode for this word |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 128 | Two binary32 results in the low 64 bits, upper half zero |
| out_flags | output | 5 | Exception bits: invalid, denormal, overflow, underflow, precision (bit 0 to 4) |

## Verification
Lane arithmetic has no state, so a fault in rounding, exponent rebias or subnormal shifting appears in the same transfer that carried the operand. It is visible on the cycle after acceptance, as a wrong low mantissa bit, a wrong exponent field or a wrong flag bit. The vector table is chosen to force each rounding decision (guard, sticky, lsb and sign) in both directions. A fault in the output register or its valid state shows up during a stall: the held word changes, the valid is lost, or in_ready rises while a word is still waiting.

// File: rtl/dp2sp_pkg.sv
package dp2sp_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_DOWN = 2'd1,
    RM_UP   = 2'd2,
    RM_ZERO = 2'd3
  } rmode_t;

  localparam int FLG_W   = 5;
  localparam int FLG_INV = 0;
  localparam int FLG_DEN = 1;
  localparam int FLG_OVF = 2;
  localparam int FLG_UNF = 3;
  localparam int FLG_PRE = 4;

  localparam int SRC_W = 64;
  localparam int DST_W = 32;
  // binary64 bias minus binary32 bias
  localparam int REBIAS = 896;

  typedef struct packed {
    logic [DST_W-1:0] value;
    logic [FLG_W-1:0] flags;
  } lane_res_t;

  // increment decision from sign, kept lsb, guard and sticky
  function automatic logic round_up(logic sgn, logic lsb, logic g, logic st, rmode_t rm);
    case (rm)
      RM_NEAR: return g & (st | lsb);
      RM_DOWN: return sgn & (g | st);
      RM_UP:   return ~sgn & (g | st);
      default: return 1'b0;
    endcase
  endfunction

  // default result when the magnitude leaves the binary32 range
  function automatic logic [DST_W-1:0] ovf_value(logic sgn, rmode_t rm);
    logic to_max;
    to_max = (rm == RM_ZERO) | ((rm == RM_DOWN) & ~sgn) | ((rm == RM_UP) & sgn);
    return to_max ? {sgn, 8'hFE, 23'h7FFFFF} : {sgn, 8'hFF, 23'h000000};
  endfunction

  function automatic lane_res_t narrow_lane(logic [SRC_W-1:0] d, rmode_t rm);
    logic               sgn;
    logic [10:0]        ex;
    logic [51:0]        fr;
    logic signed [12:0] eb;
    logic [52:0]        sig;
    logic [127:0]       wide;
    logic [6:0]         sh;
    logic [30:0]        sum;
    logic               g, st, inc;
    lane_res_t          r;
    sgn  = d[63];
    ex   = d[62:52];
    fr   = d[51:0];
    eb   = $signed({2'b00, ex}) - 13'sd896;
    sig  = {1'b1, fr};
    r    = '0;
    wide = '0;
    sh   = '0;
    sum  = '0;
    g    = 1'b0;
    st   = 1'b0;
    inc  = 1'b0;
    if (ex == 11'h7FF) begin
      if (fr == '0) begin
        r.value = {sgn, 8'hFF, 23'h0};
      end else begin
        r.value = {sgn, 8'hFF, 1'b1, fr[50:29]};
        r.flags[FLG_INV] = ~fr[51];
      end
    end else if (ex == '0) begin
      if (fr == '0) begin
        r.value = {sgn, 31'h0};
      end else begin
        // far below the binary32 subnormal range: only sticky survives
        inc = round_up(sgn, 1'b0, 1'b0, 1'b1, rm);
        r.value = {sgn, 30'h0, inc};
        r.flags[FLG_DEN] = 1'b1;
        r.flags[FLG_UNF] = 1'b1;
        r.flags[FLG_PRE] = 1'b1;
      end
    end else if (eb > 13'sd254) begin
      r.value = ovf_value(sgn, rm);
      r.flags[FLG_OVF] = 1'b1;
      r.flags[FLG_PRE] = 1'b1;
    end else if (eb >= 13'sd1) begin
      g   = fr[28];
      st  = |fr[27:0];
      inc = round_up(sgn, fr[29], g, st, rm);
      sum = {eb[7:0], fr[51:29]} + 31'(inc);
      if (sum[30:23] == 8'hFF) begin
        r.value = ovf_value(sgn, rm);
        r.flags[FLG_OVF] = 1'b1;
        r.flags[FLG_PRE] = 1'b1;
      end else begin
        r.value = {sgn, sum};
        r.flags[FLG_PRE] = g | st;
      end
    end else begin
      // tiny before rounding: align to the 2^-149 unit
      if (eb < -13'sd50) sh = 7'd80;
      else               sh = 7'(13'sd30 - eb);
      wide = {sig, 75'h0} >> sh;
      g    = wide[74];
      st   = |wide[73:0];
      inc  = round_up(sgn, wide[75], g, st, rm);
      sum  = {7'h0, wide[98:75]} + 31'(inc);
      r.value = {sgn, sum};
      r.flags[FLG_UNF] = g | st;
      r.flags[FLG_PRE] = g | st;
    end
    return r;
  endfunction

endpackage

// File: rtl/dp2sp_lane.sv
module dp2sp_lane
  import dp2sp_pkg::*;
(
  input  logic [SRC_W-1:0] src,
  input  rmode_t           rm,
  output logic [DST_W-1:0] res,
  output logic [FLG_W-1:0] flags
);

  lane_res_t conv;

  always_comb begin
    conv  = narrow_lane(src, rm);
    res   = conv.value;
    flags = conv.flags;
  end

  always_comb begin
    // R4
    if (flags[FLG_OVF]) ovf_pre_chk: assert (flags[FLG_PRE] && res[30:23] >= 8'hFE);
    // R7
    if (flags[FLG_UNF]) unf_tiny_chk: assert (flags[FLG_PRE] && res[30:24] == 7'h0);
    // R5
    if (flags[FLG_INV]) inv_qnan_chk: assert (res[30:22] == 9'h1FF);
  end

endmodule

// File: rtl/dp2sp_hold.sv
module dp2sp_hold #(
  parameter int W = 69
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_word,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_word
);

  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take)     out_word  <= in_word;
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

endmodule

// File: rtl/dp2sp_pair.sv
module dp2sp_pair
  import dp2sp_pkg::*;
#(
  parameter int LANES = 2,
  parameter int OUT_W = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [SRC_W*LANES-1:0] in_data,
  input  logic [1:0]             in_rmode,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [OUT_W-1:0]       out_data,
  output logic [FLG_W-1:0]       out_flags
);

  localparam int RES_W  = DST_W * LANES;
  localparam int ZERO_W = OUT_W - RES_W;
  localparam int WORD_W = RES_W + FLG_W;

  rmode_t           rm;
  logic [RES_W-1:0] lane_vals;
  logic [FLG_W-1:0] lane_flags [LANES];
  logic [FLG_W-1:0] merged;
  logic [WORD_W-1:0] held;

  assign rm = rmode_t'(in_rmode);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    dp2sp_lane u_lane (
      .src   (in_data[i*SRC_W +: SRC_W]),
      .rm    (rm),
      .res   (lane_vals[i*DST_W +: DST_W]),
      .flags (lane_flags[i])
    );
  end

  always_comb begin
    merged = '0;
    for (int i = 0; i < LANES; i++) merged = merged | lane_flags[i];
  end

  dp2sp_hold #(.W(WORD_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   ({merged, lane_vals}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (held)
  );

  assign out_data  = {{ZERO_W{1'b0}}, held[RES_W-1:0]};
  assign out_flags = held[WORD_W-1:RES_W];

endmodule

// File: tb/dp2sp_pair_test.sv
`timescale 1ns/1ps
module dp2sp_pair_test;

  localparam int NVEC = 26;
  localparam logic [63:0] ONE_D = 64'h3FF0000000000000;
  localparam logic [31:0] ONE_S = 32'h3F800000;

  // {binary64 operand, rounding mode, expected binary32, expected flags}
  localparam logic [102:0] VEC [NVEC] = '{
    {64'h3FF0000000000000, 2'd0, 32'h3F800000, 5'h00}, // R3 exact
    {64'hC004000000000000, 2'd0, 32'hC0200000, 5'h00}, // R3 exact negative
    {64'h3FF0000010000000, 2'd0, 32'h3F800000, 5'h10}, // R3 tie to even
    {64'h3FF0000010000000, 2'd2, 32'h3F800001, 5'h10}, // R3 up
    {64'h3FF0000030000000, 2'd0, 32'h3F800002, 5'h10}, // R3 tie odd
    {64'hBFF0000010000001, 2'd1, 32'hBF800001, 5'h10}, // R3 down negative
    {64'hBFF0000010000001, 2'd3, 32'hBF800000, 5'h10}, // R3 toward zero
    {64'h7FE0000000000000, 2'd0, 32'h7F800000, 5'h14}, // R4
    {64'h7FE0000000000000, 2'd3, 32'h7F7FFFFF, 5'h14}, // R4
    {64'hFFE0000000000000, 2'd2, 32'hFF7FFFFF, 5'h14}, // R4
    {64'hFFE0000000000000, 2'd1, 32'hFF800000, 5'h14}, // R4
    {64'h47EFFFFFF0000000, 2'd0, 32'h7F800000, 5'h14}, // R4 rounding carry
    {64'h47EFFFFFF0000000, 2'd3, 32'h7F7FFFFF, 5'h10}, // R3 truncates to max
    {64'h7FF0000000000000, 2'd0, 32'h7F800000, 5'h00}, // R5 infinity
    {64'h7FF8000000000000, 2'd0, 32'h7FC00000, 5'h00}, // R5 quiet NaN
    {64'hFFF4000000000000, 2'd0, 32'hFFE00000, 5'h01}, // R5 signalling NaN
    {64'h8000000000000000, 2'd0, 32'h80000000, 5'h00}, // R5 negative zero
    {64'h0000000000000001, 2'd0, 32'h00000000, 5'h1A}, // R6
    {64'h0000000000000001, 2'd2, 32'h00000001, 5'h1A}, // R6
    {64'h8000000000000001, 2'd1, 32'h80000001, 5'h1A}, // R6
    {64'h36A0000000000000, 2'd0, 32'h00000001, 5'h00}, // R7 exact tiny
    {64'h3690000000000000, 2'd0, 32'h00000000, 5'h18}, // R7 half ulp tie
    {64'h3690000000000000, 2'd2, 32'h00000001, 5'h18}, // R7 up
    {64'h36A8000000000000, 2'd0, 32'h00000002, 5'h18}, // R7 tie odd
    {64'h3810000000000000, 2'd0, 32'h00800000, 5'h00}, // R7 smallest normal
    {64'h380FFFFFE0000000, 2'd0, 32'h00800000, 5'h18}  // R7 rounds into normal
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [1:0]   in_rmode = 2'd0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_data;
  logic [4:0]   out_flags;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  dp2sp_pair uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_rmode  (in_rmode),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_flags (out_flags)
  );

  task automatic check(input string tag, input logic [133:0] act, input logic [133:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int i);
    if (i < 7)  return "R3";
    if (i < 12) return "R4";
    if (i == 12) return "R3";
    if (i < 17) return "R5";
    if (i < 20) return "R6";
    return "R7";
  endfunction

  task automatic send(input logic [63:0] lo, input logic [63:0] hi, input logic [1:0] rm);
    @(negedge clk);
    in_valid  = 1'b1;
    in_data   = {hi, lo};
    in_rmode  = rm;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 out_valid", {133'h0, out_valid}, 134'h0);
    check("R9 in_ready",  {133'h0, in_ready},  134'h1);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][102:39], ONE_D, VEC[i][38:37]);
      // R1 R2: lane 0 result low, lane 1 (1.0) above it, upper half zero
      check(tag_of(i), {out_valid, out_flags, out_data},
            {1'b1, VEC[i][4:0], 64'h0, ONE_S, VEC[i][36:5]});
    end

    // R1 R8: distinct lanes, flags merged from both
    send(64'hFFF4000000000000, 64'h7FE0000000000000, 2'd0);
    check("R1 placement", {6'h0, out_data}, {6'h0, 64'h0, 32'h7F800000, 32'hFFE00000});
    check("R8 flag merge", {129'h0, out_flags}, {129'h0, 5'h15});
    // R2: upper half zero even with all-ones style operands
    send(64'hFFE0000000000000, 64'h8000000000000001, 2'd2);
    check("R2 upper zero", {6'h0, out_data}, {6'h0, 64'h0, 32'h80000000, 32'hFF7FFFFF});

    // R10 stall: word A held while out_ready is low
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_data   = {ONE_D, 64'hC004000000000000};
    in_rmode  = 2'd0;
    @(negedge clk);
    in_data   = {64'h7FE0000000000000, 64'h3FF0000010000000};
    in_rmode  = 2'd2;
    check("R10 in_ready low", {133'h0, in_ready}, 134'h0);
    @(negedge clk);
    check("R10 hold", {out_valid, out_flags, out_data},
          {1'b1, 5'h00, 64'h0, ONE_S, 32'hC0200000});
    check("R10 in_ready still low", {133'h0, in_ready}, 134'h0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next word", {out_valid, out_flags, out_data},
          {1'b1, 5'h14, 64'h0, 32'h7F800000, 32'h3F800001});
    @(negedge clk);
    check("R10 drained", {133'h0, out_valid}, 134'h0);

    // R9 reset mid-stream clears the output
    send(ONE_D, ONE_D, 2'd0);
    out_ready = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears", {132'h0, out_valid, in_ready}, 134'h1);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule